// File: doc/BRIEF.md
# Pad-to-Channel Interrupt Router

This block watches a wide bus of chip pad inputs and hands a small number of them, eight at most, to an upstream interrupt controller. Each of the eight output channels picks one pad by index, optionally inverts it, and optionally passes it through a glitch filter. It then presents the result either as a level or as a single-cycle pulse. The upstream controller therefore only ever sees active-high levels or rising-edge pulses, even when the pad is active-low or the event of interest is a falling edge.

Software sets the block up through a four-word register bank on a simple 32-bit write bus with combinational read-back. Deciding which pad goes to which channel is left to software. The block only carries out the selection it is given.

Every pad passes through a two-flop synchronizer before any channel uses it. Each channel runs a small state machine with two states. In CS_STEADY the accepted value matches the conditioned input. In CS_QUALIFY a change is being timed. The transitions are:
- *start* (CS_STEADY to CS_QUALIFY): the input differs and the filter is enabled.
- *reject* (CS_QUALIFY to CS_STEADY): the input returns to the accepted value before the window ends.
- *accept* (CS_QUALIFY to CS_STEADY): the change held for the whole window and is taken.
- *reload* (either state to CS_STEADY): a configuration change forces the state machine back to CS_STEADY and reloads the history.

With the filter set to zero, a change in CS_STEADY is taken at once and the state does not change.

Top module: `pad_irq_router`

## Requirements
- R1: A synchronous active-high reset clears every configuration field to zero, so all words read 0 and every channel output is 0 on the first cycle after reset.
- R2: Word 0x0 holds the edge-enable of channel n in bit n and its low flag in bit 16+n, and reads zero in all other bits. Word 0xC holds a 4-bit filter length for channel n in bits [4n+3:4n]. Writes to any address other than 0x0, 0x4, 0x8 and 0xC are ignored, and reads of such addresses return 0.
- R3: Channel n takes its pad index from byte (n mod 4) of word 0x4 for channels 0–3, or of word 0x8 for channels 4–7. With the filter at 0 and level mode, a pad change made in cycle c shows on the output in cycle c+3. This holds for the last mapped pad as well.
- R4: When the low flag is set, the selected pad is inverted before the filter and mode stages, so an active-low pad appears as an active-high level.
- R5: In edge mode, the output is high for exactly one cycle when the conditioned signal goes from 0 to 1. With the low flag clear this is a pad rising edge, and with the low flag set it is a pad falling edge. The opposite pad edge produces nothing.
- R6: A filter length N>0 accepts a change only after the conditioned input has differed from the accepted value for 2N consecutive samples. A shorter excursion is discarded. With N=2, a held change appears in cycle c+6.
- R7: A pad index at or above NUM_PADS selects a constant 0 before inversion. In level mode such a channel shows the low flag, and in edge mode it never pulses.
- R8: A write that changes a channel's pad index, edge-enable or low flag forces that channel's output to 0 in the following cycle and reloads its history from the new selection, so the reconfiguration itself raises no pulse.
- R9: Channels are independent: a pad routed to one channel has no effect on another channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe for the register bank |
| bus_addr | input | 4 | Byte address of the word (0x0, 0x4, 0x8, 0xC) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pads_i | input | NUM_PADS | Asynchronous pad levels |
| chan_irq_o | output | 8 | Interrupt lines toward the upstream controller |

## Verification
The bench builds the block with NUM_PADS set to 40. This makes most of the 8-bit index range unmapped, so a channel pointing at index 200 exercises the constant-input path. Pad 39 then serves as the last mapped index and covers the top boundary of the mux. A filter length of 2 keeps the 4-sample qualify window short enough that the test can show a rejected 3-sample glitch and an accepted held change side by side.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
    localparam int CH_COUNT  = 8;
    localparam int IDX_W     = 8;
    localparam int FLT_W     = 4;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 4;
    localparam int GROUP     = 4;
    localparam int LOW_BASE  = 16;
    localparam int MUX_SPAN  = 1 << IDX_W;
    localparam int CNT_W     = FLT_W + 1;

    localparam logic [ADDR_W-1:0] ADDR_MODE = 4'h0;
    localparam logic [ADDR_W-1:0] ADDR_SELA = 4'h4;
    localparam logic [ADDR_W-1:0] ADDR_SELB = 4'h8;
    localparam logic [ADDR_W-1:0] ADDR_FILT = 4'hC;

    typedef struct packed {
        logic             edge_en;
        logic             low;
        logic [IDX_W-1:0] pad;
        logic [FLT_W-1:0] flt;
    } chan_cfg_t;

    typedef enum logic {
        CS_STEADY  = 1'b0,
        CS_QUALIFY = 1'b1
    } chan_state_t;
endpackage

// File: rtl/pirq_regs.sv
module pirq_regs
    import pirq_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           bus_wr,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [DATA_W-1:0]              bus_wdata,
    output logic [DATA_W-1:0]              bus_rdata,
    output chan_cfg_t [CH_COUNT-1:0]       cfg_o,
    output logic [CH_COUNT-1:0]            touch_o
);
    chan_cfg_t [CH_COUNT-1:0] cfg_q;
    logic [CH_COUNT-1:0]      touch_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            touch_q <= '0;
        end else begin
            touch_q <= '0;
            if (bus_wr) begin
                case (bus_addr)
                    ADDR_MODE: begin
                        for (int n = 0; n < CH_COUNT; n++) begin
                            cfg_q[n].edge_en <= bus_wdata[n];
                            cfg_q[n].low     <= bus_wdata[LOW_BASE+n];
                            touch_q[n]       <= (bus_wdata[n] != cfg_q[n].edge_en) ||
                                                (bus_wdata[LOW_BASE+n] != cfg_q[n].low);
                        end
                    end
                    ADDR_SELA: begin
                        for (int n = 0; n < GROUP; n++) begin
                            cfg_q[n].pad <= bus_wdata[n*IDX_W +: IDX_W];
                            touch_q[n]   <= bus_wdata[n*IDX_W +: IDX_W] != cfg_q[n].pad;
                        end
                    end
                    ADDR_SELB: begin
                        for (int n = 0; n < GROUP; n++) begin
                            cfg_q[GROUP+n].pad <= bus_wdata[n*IDX_W +: IDX_W];
                            touch_q[GROUP+n]   <= bus_wdata[n*IDX_W +: IDX_W] != cfg_q[GROUP+n].pad;
                        end
                    end
                    ADDR_FILT: begin
                        for (int n = 0; n < CH_COUNT; n++) begin
                            cfg_q[n].flt <= bus_wdata[n*FLT_W +: FLT_W];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_MODE: begin
                for (int n = 0; n < CH_COUNT; n++) begin
                    bus_rdata[n]          = cfg_q[n].edge_en;
                    bus_rdata[LOW_BASE+n] = cfg_q[n].low;
                end
            end
            ADDR_SELA: begin
                for (int n = 0; n < GROUP; n++) bus_rdata[n*IDX_W +: IDX_W] = cfg_q[n].pad;
            end
            ADDR_SELB: begin
                for (int n = 0; n < GROUP; n++) bus_rdata[n*IDX_W +: IDX_W] = cfg_q[GROUP+n].pad;
            end
            ADDR_FILT: begin
                for (int n = 0; n < CH_COUNT; n++) bus_rdata[n*FLT_W +: FLT_W] = cfg_q[n].flt;
            end
            default: ;
        endcase
    end

    assign cfg_o   = cfg_q;
    assign touch_o = touch_q;
endmodule

// File: rtl/pirq_sync.sv
module pirq_sync #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[DEPTH-1];
endmodule

// File: rtl/pirq_channel.sv
module pirq_channel
    import pirq_pkg::*;
#(
    parameter int NUM_PADS = 133
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PADS-1:0] pads_s,
    input  chan_cfg_t           cfg,
    input  logic                touch,
    output logic                irq
);
    logic [MUX_SPAN-1:0] pad_ext;
    logic                cond;
    logic [CNT_W-1:0]    qual_len;
    logic                window_done;

    chan_state_t      state_q, state_d;
    logic             flt_q, flt_d;
    logic             prev_q, prev_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        pad_ext                 = '0;
        pad_ext[NUM_PADS-1:0]   = pads_s;
    end

    assign cond        = pad_ext[cfg.pad] ^ cfg.low;
    assign qual_len    = {cfg.flt, 1'b0};
    assign window_done = (cnt_q + 1'b1) >= qual_len;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CS_STEADY;
            flt_q   <= 1'b0;
            prev_q  <= 1'b0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            flt_q   <= flt_d;
            prev_q  <= prev_d;
            cnt_q   <= cnt_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        flt_d   = flt_q;
        prev_d  = flt_q;
        cnt_d   = cnt_q;
        if (touch) begin
            state_d = CS_STEADY;
            flt_d   = cond;
            prev_d  = cond;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                CS_STEADY: begin
                    if (cond != flt_q) begin
                        if (cfg.flt == '0) begin
                            flt_d = cond;
                        end else begin
                            state_d = CS_QUALIFY;
                            cnt_d   = 1;
                        end
                    end
                end
                CS_QUALIFY: begin
                    if (cond == flt_q) begin
                        state_d = CS_STEADY;
                        cnt_d   = '0;
                    end else if (window_done) begin
                        state_d = CS_STEADY;
                        flt_d   = cond;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // output logic
    always_comb begin
        if (touch)            irq = 1'b0;
        else if (cfg.edge_en) irq = flt_q & ~prev_q;
        else                  irq = flt_q;
    end
endmodule

// File: rtl/pad_irq_router.sv
module pad_irq_router
    import pirq_pkg::*;
#(
    parameter int NUM_PADS   = 133,
    parameter int SYNC_DEPTH = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic [3:0]           bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_PADS-1:0]  pads_i,
    output logic [7:0]           chan_irq_o
);
    chan_cfg_t [CH_COUNT-1:0] cfg_w;
    logic [CH_COUNT-1:0]      touch_w;
    logic [NUM_PADS-1:0]      pads_s;

    pirq_regs regs_i (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cfg_o     (cfg_w),
        .touch_o   (touch_w)
    );

    pirq_sync #(.WIDTH(NUM_PADS), .DEPTH(SYNC_DEPTH)) sync_i (
        .clk  (clk),
        .rst  (rst),
        .din  (pads_i),
        .dout (pads_s)
    );

    for (genvar n = 0; n < CH_COUNT; n++) begin : g_ch
        pirq_channel #(.NUM_PADS(NUM_PADS)) ch_i (
            .clk    (clk),
            .rst    (rst),
            .pads_s (pads_s),
            .cfg    (cfg_w[n]),
            .touch  (touch_w[n]),
            .irq    (chan_irq_o[n])
        );
    end
endmodule

// File: rtl/pirq_checker.sv
module pirq_checker
    import pirq_pkg::*;
#(
    parameter int NUM_PADS = 133
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     bus_wr,
    input logic [3:0]               bus_addr,
    input logic [31:0]              bus_wdata,
    input logic [31:0]              bus_rdata,
    input logic [7:0]               chan_irq_o,
    input chan_cfg_t [CH_COUNT-1:0] cfg
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (chan_irq_o == '0)); // R1

    AST_MODE_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_MODE) |-> (bus_rdata[31:24] == '0 && bus_rdata[15:8] == '0)); // R2

    for (genvar n = 0; n < CH_COUNT; n++) begin : g_chk
        localparam logic [3:0] SEL_ADDR = (n < GROUP) ? ADDR_SELA : ADDR_SELB;
        localparam int         SEL_LSB  = (n % GROUP) * IDX_W;

        AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
            (chan_irq_o[n] && cfg[n].edge_en) |=> (!chan_irq_o[n] || !cfg[n].edge_en)); // R5

        AST_UNMAPPED_SILENT: assert property (@(posedge clk) disable iff (rst)
            (cfg[n].edge_en && (int'(cfg[n].pad) >= NUM_PADS)) |-> !chan_irq_o[n]); // R7

        AST_RECONF_QUIET: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && bus_addr == SEL_ADDR && bus_wdata[SEL_LSB +: IDX_W] != cfg[n].pad)
            |=> !chan_irq_o[n]); // R8
    end
endmodule

bind pad_irq_router pirq_checker #(.NUM_PADS(NUM_PADS)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .chan_irq_o (chan_irq_o),
    .cfg        (cfg_w)
);

// File: tb/pad_irq_router_tb.sv
module pad_irq_router_tb_top;
    localparam int NP = 40;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pads = '0;
    logic [7:0]    irq;

    pad_irq_router #(.NUM_PADS(NP)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .pads_i     (pads),
        .chan_irq_o (irq)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    at;
        int    ch;
        logic  val;
        string tag;
    } exp_t;
    exp_t sbq[$];

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    task automatic report(input string tag, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // monitor: pops expected samples when their cycle comes up
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].at <= cyc) begin
            exp_t e;
            e = sbq.pop_front();
            if (e.at < cyc) report(e.tag, "missed slot", e.at, cyc);
            else report(e.tag, $sformatf("ch%0d cycle %0d", e.ch, e.at), {31'd0, irq[e.ch]}, {31'd0, e.val});
        end
    end

    task automatic expect_at(input int off, input int ch, input logic v, input string tag);
        exp_t e;
        e.at = cyc + off; e.ch = ch; e.val = v; e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [3:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        report(tag, $sformatf("read 0x%0h", a), bus_rdata, exp);
    endtask

    initial begin
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(1);

        // R1: reset state
        bus_read(4'h0, 32'h0, "R1");
        bus_read(4'h4, 32'h0, "R1");
        bus_read(4'h8, 32'h0, "R1");
        bus_read(4'hC, 32'h0, "R1");
        report("R1", "outputs after reset", {24'd0, irq}, 32'h0);

        // R2: field layout, unused bits, stray address
        bus_write(4'h0, 32'hFFFF_FFFF);
        bus_read(4'h0, 32'h00FF_00FF, "R2");
        bus_write(4'h0, 32'h0);
        bus_write(4'hC, 32'h8765_4321);
        bus_read(4'hC, 32'h8765_4321, "R2");
        bus_write(4'hC, 32'h0);
        bus_write(4'h2, 32'hFFFF_FFFF);
        bus_read(4'h2, 32'h0, "R2");
        bus_read(4'h0, 32'h0, "R2");
        bus_read(4'h4, 32'h0, "R2");
        wait_cyc(3);

        // R3 / R9: selection and latency, channel independence
        bus_write(4'h4, 32'h0000_0005);
        bus_write(4'h8, 32'h0000_0900);
        wait_cyc(2);
        bus_read(4'h4, 32'h0000_0005, "R3");
        bus_read(4'h8, 32'h0000_0900, "R3");
        pads[5] = 1'b1;
        expect_at(2, 0, 1'b0, "R3");
        expect_at(3, 0, 1'b1, "R3");
        expect_at(3, 5, 1'b0, "R9");
        wait_cyc(4);
        pads[9] = 1'b1;
        expect_at(2, 5, 1'b0, "R9");
        expect_at(3, 5, 1'b1, "R9");
        expect_at(3, 0, 1'b1, "R9");
        wait_cyc(4);

        // R4: active-low level
        bus_write(4'h0, 32'h0001_0000);
        report("R8", "output in reconfig cycle", {31'd0, irq[0]}, 32'h0);
        expect_at(1, 0, 1'b0, "R4");
        wait_cyc(1);
        pads[5] = 1'b0;
        expect_at(2, 0, 1'b0, "R4");
        expect_at(3, 0, 1'b1, "R4");
        wait_cyc(4);

        // R5: rising edge pulse
        bus_write(4'h0, 32'h0000_0001);
        wait_cyc(2);
        pads[5] = 1'b1;
        expect_at(2, 0, 1'b0, "R5");
        expect_at(3, 0, 1'b1, "R5");
        expect_at(4, 0, 1'b0, "R5");
        wait_cyc(5);
        pads[5] = 1'b0;
        expect_at(3, 0, 1'b0, "R5");
        expect_at(4, 0, 1'b0, "R5");
        wait_cyc(5);

        // R5 / R8: falling edge, and reconfig that flips the conditioned value
        bus_write(4'h0, 32'h0001_0001);
        expect_at(1, 0, 1'b0, "R8");
        expect_at(2, 0, 1'b0, "R8");
        expect_at(3, 0, 1'b0, "R8");
        wait_cyc(4);
        pads[5] = 1'b1;
        expect_at(3, 0, 1'b0, "R5");
        expect_at(4, 0, 1'b0, "R5");
        wait_cyc(5);
        pads[5] = 1'b0;
        expect_at(3, 0, 1'b1, "R5");
        expect_at(4, 0, 1'b0, "R5");
        wait_cyc(5);

        // R8: switching the pad index onto a high pad in rising-edge mode
        bus_write(4'h0, 32'h0000_0001);
        wait_cyc(3);
        pads[6] = 1'b1;
        wait_cyc(4);
        bus_write(4'h4, 32'h0000_0006);
        report("R8", "output in reselect cycle", {31'd0, irq[0]}, 32'h0);
        expect_at(1, 0, 1'b0, "R8");
        expect_at(2, 0, 1'b0, "R8");
        expect_at(3, 0, 1'b0, "R8");
        wait_cyc(4);

        // R6: glitch filter, N = 2 on channel 1
        bus_write(4'h4, 32'h0000_0C06);
        bus_write(4'hC, 32'h0000_0020);
        wait_cyc(2);
        bus_read(4'hC, 32'h0000_0020, "R6");
        pads[12] = 1'b1;
        for (int k = 3; k <= 9; k++) expect_at(k, 1, 1'b0, "R6");
        wait_cyc(3);
        pads[12] = 1'b0;
        wait_cyc(8);
        pads[12] = 1'b1;
        expect_at(5, 1, 1'b0, "R6");
        expect_at(6, 1, 1'b1, "R6");
        expect_at(7, 1, 1'b1, "R6");
        wait_cyc(8);

        // R7: unmapped index on channel 2, active-low level
        bus_write(4'h4, 32'h00C8_0C06);
        bus_write(4'h0, 32'h0004_0001);
        wait_cyc(2);
        report("R7", "unmapped low-flag level", {31'd0, irq[2]}, 32'h1);
        pads = '1;
        expect_at(3, 2, 1'b1, "R7");
        expect_at(4, 2, 1'b1, "R7");
        wait_cyc(5);
        pads = '0;
        expect_at(3, 2, 1'b1, "R7");
        wait_cyc(5);

        // R3: last mapped pad on channel 3
        bus_write(4'h4, 32'h27C8_0C06);
        wait_cyc(2);
        pads[39] = 1'b1;
        expect_at(2, 3, 1'b0, "R3");
        expect_at(3, 3, 1'b1, "R3");
        wait_cyc(5);
        bus_read(4'h4, 32'h27C8_0C06, "R3");

        for (int k = 0; k < 20 && sbq.size() > 0; k++) wait_cyc(1);
        report("R9", "scoreboard drained", sbq.size(), 32'h0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule